// File: doc/BRIEF.md
# Register-Controlled Shift Execution Unit

This unit executes a move-with-shift operation whose shift distance comes from a register. The instruction word arrives together with a selector naming its format: a 32-bit fixed format, a 16-bit compact format or a 32-bit wide compact format. A decoder recovers the destination, source and amount register indices, the shift kind and whether flags are written. It also reports words that do not belong to this operation and operands that make the result unpredictable. The register file lives outside the block. It returns the source operand and the amount register value in the same cycle, together with the incoming N, Z and C flags.

The shifter takes the low byte of the amount register, so distances of 32 to 255 are valid and have fixed results. Result, carry, flags and decode fields are captured in one register stage. They appear on the clock edge that follows an accepted request and are held until the next request.

Top module: `rsh_exec_unit`

## Requirements
- R1: Only bits [7:0] of `amt_val` set the shift distance; bits [31:8] have no effect on `result` or `carry_out`.
- R2: A distance of 0 gives `result` equal to `src_val` and `carry_out` equal to `carry_in`, for every shift kind.
- R3: Shift kind 0 is logical left and kind 1 is logical right. For distances 1 to 31 the carry is the last bit shifted out. At 32 the result is 0 and the carry is bit 0 (left) or bit 31 (right). Above 32 both the result and the carry are 0.
- R4: Shift kind 2 is arithmetic right. At 32 or more every result bit and the carry equal operand bit 31.
- R5: Shift kind 3 rotates right by the distance modulo 32. For any nonzero distance, including multiples of 32, `carry_out` equals `result` bit 31.
- R6: When `flags_we` is 1, `flag_n` is result bit 31, `flag_z` is 1 exactly when the result is zero, and `flag_c` is `carry_out`. When `flags_we` is 0, the three flags repeat `n_in`, `z_in` and `carry_in`.
- R7: With `enc_sel`=0, the word matches when bits [27:21]=0001101, bit 7=0, bit 4=1 and bits [31:28]≠1111. Then bit 20 enables flags, `rd_idx`=[15:12], `rs_idx`=[11:8], `shift_kind`=[6:5] and `rm_idx`=[3:0]. A non-matching word raises `foreign`.
- R8: With `enc_sel`=1, the word is `instr[15:0]`, bits [15:10]=010000, and op=[9:6] is 0010, 0011, 0100 or 0111. The shift kind is {op[2],op[0]}, `rs_idx`=[5:3], and `rd_idx`=`rm_idx`=[2:0]. Flags are written only when `in_it_block` is 0.
- R9: A compact op outside the four listed, or `enc_sel`=3, raises `foreign`, and then `flags_we` is 0.
- R10: With `enc_sel`=2, the first halfword `instr[31:16]` is 111110100, shift kind, flag bit S, then Rm. The second halfword `instr[15:0]` is 1111, Rd, 0000, Rs. Flags are written when S=1.
- R11: For `enc_sel` 0 and 2, `unpred` is 1 when Rd, Rm or Rs is 15 (and for format 0 also when bits [19:16] are nonzero). The compact format never raises it.
- R12: Outputs change only on the clock edge after `in_valid`=1, and `out_valid` is 1 for exactly that cycle. A synchronous reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| enc_sel | input | 2 | Format: 0 fixed, 1 compact, 2 wide compact, 3 none |
| instr | input | 32 | Instruction word |
| in_it_block | input | 1 | Instruction lies in a conditional block |
| src_val | input | 32 | Value of the source register |
| amt_val | input | 32 | Value of the amount register |
| carry_in | input | 1 | Current C flag |
| n_in | input | 1 | Current N flag |
| z_in | input | 1 | Current Z flag |
| out_valid | output | 1 | Result registered this cycle |
| rd_idx | output | 4 | Destination register index |
| rm_idx | output | 4 | Source register index |
| rs_idx | output | 4 | Amount register index |
| shift_kind | output | 2 | Decoded shift kind |
| result | output | 32 | Shifted value |
| carry_out | output | 1 | Shifter carry |
| flag_n | output | 1 | Next N flag |
| flag_z | output | 1 | Next Z flag |
| flag_c | output | 1 | Next C flag |
| flags_we | output | 1 | Flags are to be written |
| unpred | output | 1 | Register 15 or nonzero reserved bits used |
| foreign | output | 1 | Word is not this operation |

## Verification
The assertions assume that `in_valid` is low while reset is asserted. They also assume that every input is stable and known at each edge where `in_valid` is high, because they relate registered outputs to the request of the previous cycle through `$past`. The bench drives all inputs on the falling edge, holds `in_valid` low during reset and for the cycle before each sample, and samples results on the falling edge after the capture edge.

// File: rtl/rsh_pkg.sv
package rsh_pkg;
  localparam int REG_W = 4;
  localparam logic [REG_W-1:0] REG_PC = 4'hF;

  typedef enum logic [1:0] {SK_LSL = 2'd0, SK_LSR = 2'd1, SK_ASR = 2'd2, SK_ROR = 2'd3} shift_kind_e;
  typedef enum logic [1:0] {FMT_FIXED = 2'd0, FMT_NARROW = 2'd1, FMT_WIDE = 2'd2, FMT_NONE = 2'd3} fmt_e;

  typedef struct packed {
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rm;
    logic [REG_W-1:0] rs;
    shift_kind_e      kind;
    logic             setf;
    logic             unpred;
    logic             foreign;
  } dec_t;
endpackage

// File: rtl/rsh_decode.sv
module rsh_decode
  import rsh_pkg::*;
(
  input  logic [31:0] instr,
  input  logic [1:0]  enc_sel,
  input  logic        in_it,
  output dec_t        dec
);
  logic [15:0] hw_hi, hw_lo;
  logic [3:0]  op;

  assign hw_hi = instr[31:16];
  assign hw_lo = instr[15:0];
  assign op    = hw_lo[9:6];

  always_comb begin
    dec = '0;
    case (fmt_e'(enc_sel))
      FMT_FIXED: begin
        dec.rd      = instr[15:12];
        dec.rs      = instr[11:8];
        dec.rm      = instr[3:0];
        dec.kind    = shift_kind_e'(instr[6:5]);
        dec.setf    = instr[20];
        dec.foreign = !((instr[27:21] == 7'b0001101) && !instr[7] && instr[4]
                        && (instr[31:28] != 4'hF));
        dec.unpred  = (dec.rd == REG_PC) || (dec.rm == REG_PC) || (dec.rs == REG_PC)
                      || (instr[19:16] != 4'h0);
      end
      FMT_NARROW: begin
        dec.rd      = {1'b0, hw_lo[2:0]};
        dec.rm      = {1'b0, hw_lo[2:0]};
        dec.rs      = {1'b0, hw_lo[5:3]};
        dec.kind    = shift_kind_e'({op[2], op[0]});
        dec.setf    = !in_it;
        dec.foreign = !((hw_lo[15:10] == 6'b010000) &&
                        ((op == 4'b0010) || (op == 4'b0011) || (op == 4'b0100) || (op == 4'b0111)));
        dec.unpred  = 1'b0;
      end
      FMT_WIDE: begin
        dec.rm      = hw_hi[3:0];
        dec.rd      = hw_lo[11:8];
        dec.rs      = hw_lo[3:0];
        dec.kind    = shift_kind_e'(hw_hi[6:5]);
        dec.setf    = hw_hi[4];
        dec.foreign = !((hw_hi[15:7] == 9'b111110100) && (hw_lo[15:12] == 4'hF)
                        && (hw_lo[7:4] == 4'h0));
        dec.unpred  = (dec.rd == REG_PC) || (dec.rm == REG_PC) || (dec.rs == REG_PC);
      end
      default: dec.foreign = 1'b1;
    endcase
  end
endmodule

// File: rtl/rsh_shifter.sv
module rsh_shifter
  import rsh_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] opnd,
  input  logic [AMT_W-1:0]  amt,
  input  shift_kind_e       kind,
  input  logic              c_in,
  output logic [DATA_W-1:0] res,
  output logic              c_out
);
  localparam int CW = $clog2(DATA_W + 2);
  localparam int RW = $clog2(DATA_W);

  logic [31:0]         amt_u;
  logic [CW-1:0]       amt_lin, amt_asr;
  logic [2*DATA_W-1:0] lsl_w, lsr_w, asr_w, ror_w;

  always_comb begin
    amt_u   = 32'(amt);
    amt_lin = (amt_u > 32'(DATA_W + 1)) ? CW'(DATA_W + 1) : CW'(amt_u);
    amt_asr = (amt_u > 32'(DATA_W))     ? CW'(DATA_W)     : CW'(amt_u);
    lsl_w   = {{DATA_W{1'b0}}, opnd} << amt_lin;
    lsr_w   = {opnd, {DATA_W{1'b0}}} >> amt_lin;
    asr_w   = $signed({opnd, {DATA_W{1'b0}}}) >>> amt_asr;
    ror_w   = {opnd, opnd} >> amt[RW-1:0];

    case (kind)
      SK_LSL: begin res = lsl_w[DATA_W-1:0];        c_out = lsl_w[DATA_W];   end
      SK_LSR: begin res = lsr_w[2*DATA_W-1:DATA_W]; c_out = lsr_w[DATA_W-1]; end
      SK_ASR: begin res = asr_w[2*DATA_W-1:DATA_W]; c_out = asr_w[DATA_W-1]; end
      default: begin res = ror_w[DATA_W-1:0];       c_out = ror_w[DATA_W-1]; end
    endcase

    if (amt_u == 32'd0) begin
      res   = opnd;
      c_out = c_in;
    end
  end
endmodule

// File: rtl/rsh_exec_unit.sv
module rsh_exec_unit
  import rsh_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        enc_sel,
  input  logic [31:0]       instr,
  input  logic              in_it_block,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] amt_val,
  input  logic              carry_in,
  input  logic              n_in,
  input  logic              z_in,
  output logic              out_valid,
  output logic [3:0]        rd_idx,
  output logic [3:0]        rm_idx,
  output logic [3:0]        rs_idx,
  output logic [1:0]        shift_kind,
  output logic [DATA_W-1:0] result,
  output logic              carry_out,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flags_we,
  output logic              unpred,
  output logic              foreign
);
  dec_t              dec;
  logic [DATA_W-1:0] sh_res;
  logic              sh_c;
  logic              wr_flags;
  logic              unused_amt_hi;

  assign unused_amt_hi = ^amt_val[DATA_W-1:AMT_W];

  rsh_decode u_dec (
    .instr   (instr),
    .enc_sel (enc_sel),
    .in_it   (in_it_block),
    .dec     (dec)
  );

  rsh_shifter #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_shf (
    .opnd  (src_val),
    .amt   (amt_val[AMT_W-1:0]),
    .kind  (dec.kind),
    .c_in  (carry_in),
    .res   (sh_res),
    .c_out (sh_c)
  );

  assign wr_flags = dec.setf && !dec.foreign;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      rd_idx     <= '0;
      rm_idx     <= '0;
      rs_idx     <= '0;
      shift_kind <= '0;
      result     <= '0;
      carry_out  <= 1'b0;
      flag_n     <= 1'b0;
      flag_z     <= 1'b0;
      flag_c     <= 1'b0;
      flags_we   <= 1'b0;
      unpred     <= 1'b0;
      foreign    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        rd_idx     <= dec.rd;
        rm_idx     <= dec.rm;
        rs_idx     <= dec.rs;
        shift_kind <= dec.kind;
        result     <= sh_res;
        carry_out  <= sh_c;
        flags_we   <= wr_flags;
        flag_n     <= wr_flags ? sh_res[DATA_W-1]        : n_in;
        flag_z     <= wr_flags ? (sh_res == '0)          : z_in;
        flag_c     <= wr_flags ? sh_c                    : carry_in;
        unpred     <= dec.unpred;
        foreign    <= dec.foreign;
      end
    end
  end
endmodule

// File: rtl/rsh_exec_checker.sv
module rsh_exec_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        enc_sel,
  input logic [DATA_W-1:0] src_val,
  input logic [7:0]        amt_lo,
  input logic              carry_in,
  input logic              out_valid,
  input logic [1:0]        shift_kind,
  input logic [DATA_W-1:0] result,
  input logic              carry_out,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_c,
  input logic              flags_we,
  input logic              unpred,
  input logic              foreign
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R12
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> (out_valid == $past(in_valid)));

  // R2
  zero_amt_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && amt_lo == 8'd0) |=> (result == $past(src_val) && carry_out == $past(carry_in)));

  // R5
  ror_carry_msb_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && shift_kind == 2'b11 && $past(amt_lo) != 8'd0) |-> (carry_out == result[DATA_W-1]));

  // R6
  flag_update_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && flags_we) |-> (flag_n == result[DATA_W-1] && flag_z == (result == '0) && flag_c == carry_out));

  // R9
  foreign_no_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && foreign) |-> !flags_we);

  // R11
  compact_never_unpred_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && unpred) |-> ($past(enc_sel) != 2'b01));
endmodule

bind rsh_exec_unit rsh_exec_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .enc_sel    (enc_sel),
  .src_val    (src_val),
  .amt_lo     (amt_val[7:0]),
  .carry_in   (carry_in),
  .out_valid  (out_valid),
  .shift_kind (shift_kind),
  .result     (result),
  .carry_out  (carry_out),
  .flag_n     (flag_n),
  .flag_z     (flag_z),
  .flag_c     (flag_c),
  .flags_we   (flags_we),
  .unpred     (unpred),
  .foreign    (foreign)
);

// File: tb/rsh_exec_unit_tb.sv
module rsh_exec_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;

  // {kind, amt_val, src_val, carry_in, exp_result, exp_carry}
  localparam logic [99:0] VEC [NVEC] = '{
    {2'd0, 32'h0000_0004, 32'h0000_00F1, 1'b0, 32'h0000_0F10, 1'b0},
    {2'd0, 32'h0000_0020, 32'h8000_0001, 1'b0, 32'h0000_0000, 1'b1},
    {2'd0, 32'h0000_0021, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 1'b0},
    {2'd0, 32'h0000_001F, 32'h0000_0003, 1'b0, 32'h8000_0000, 1'b1},
    {2'd1, 32'h0000_0001, 32'h8000_0001, 1'b0, 32'h4000_0000, 1'b1},
    {2'd1, 32'h0000_0020, 32'h8000_0000, 1'b0, 32'h0000_0000, 1'b1},
    {2'd1, 32'hABCD_EFC8, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 1'b0},
    {2'd2, 32'h0000_0004, 32'h8000_0010, 1'b1, 32'hF800_0001, 1'b0},
    {2'd2, 32'h0000_0064, 32'h8000_0000, 1'b0, 32'hFFFF_FFFF, 1'b1},
    {2'd2, 32'h0000_0028, 32'h7FFF_FFFF, 1'b1, 32'h0000_0000, 1'b0},
    {2'd3, 32'h0000_0001, 32'h0000_0001, 1'b0, 32'h8000_0000, 1'b1},
    {2'd3, 32'h0000_0040, 32'h1234_5678, 1'b1, 32'h1234_5678, 1'b0},
    {2'd3, 32'h0000_0024, 32'h0000_00F0, 1'b1, 32'h0000_000F, 1'b0},
    {2'd3, 32'hFFFF_FF00, 32'h8000_0000, 1'b0, 32'h8000_0000, 1'b0},
    {2'd1, 32'h1234_5600, 32'h0000_0000, 1'b1, 32'h0000_0000, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  enc_sel = 2'd0;
  logic [31:0] instr = '0;
  logic        in_it_block = 1'b0;
  logic [31:0] src_val = '0;
  logic [31:0] amt_val = '0;
  logic        carry_in = 1'b0;
  logic        n_in = 1'b0;
  logic        z_in = 1'b0;
  logic        out_valid;
  logic [3:0]  rd_idx, rm_idx, rs_idx;
  logic [1:0]  shift_kind;
  logic [31:0] result;
  logic        carry_out, flag_n, flag_z, flag_c, flags_we, unpred, foreign;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rsh_exec_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .enc_sel(enc_sel), .instr(instr),
    .in_it_block(in_it_block), .src_val(src_val), .amt_val(amt_val), .carry_in(carry_in),
    .n_in(n_in), .z_in(z_in), .out_valid(out_valid), .rd_idx(rd_idx), .rm_idx(rm_idx),
    .rs_idx(rs_idx), .shift_kind(shift_kind), .result(result), .carry_out(carry_out),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flags_we(flags_we),
    .unpred(unpred), .foreign(foreign)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fixed_word(input logic s, input logic [3:0] cnd,
      input logic [3:0] rd, input logic [3:0] rs, input logic [1:0] st, input logic [3:0] rm);
    return {cnd, 7'b0001101, s, 4'h0, rd, rs, 1'b0, st, 1'b1, rm};
  endfunction

  // drives one request; returns at the falling edge after the capture edge
  task automatic issue(input logic [1:0] es, input logic [31:0] iw, input logic it,
      input logic [31:0] sv, input logic [31:0] av, input logic ci, input logic ni, input logic zi);
    @(negedge clk);
    enc_sel = es; instr = iw; in_it_block = it; src_val = sv; amt_val = av;
    carry_in = ci; n_in = ni; z_in = zi; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 reset out_valid", 32'(out_valid), 32'd0);
    chk("R12 reset result", result, 32'd0);
    chk("R12 reset flags_we", 32'(flags_we), 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      logic [1:0]  k;
      logic [31:0] a, s, er;
      logic        ci, ec;
      string       tag;
      {k, a, s, ci, er, ec} = VEC[i];
      tag = (k == 2'd2) ? "R4" : (k == 2'd3) ? "R5" : "R3";
      if (a[7:0] == 8'd0) tag = "R2";
      issue(2'd0, fixed_word(1'b1, 4'hE, 4'd1, 4'd2, k, 4'd3), 1'b0, s, a, ci, 1'b0, 1'b0);
      chk({tag, " result"}, result, er);
      chk({tag, " carry"}, 32'(carry_out), 32'(ec));
      chk("R6 flag_n", 32'(flag_n), 32'(er[31]));
      chk("R6 flag_z", 32'(flag_z), 32'(er == 32'd0));
      chk("R6 flag_c", 32'(flag_c), 32'(ec));
      chk("R12 out_valid", 32'(out_valid), 32'd1);
    end

    // R12 hold: no request, outputs keep last values and out_valid drops
    @(negedge clk);
    chk("R12 out_valid drop", 32'(out_valid), 32'd0);
    chk("R12 result hold", result, VEC[NVEC-1][32:1]);

    // R1 upper bits of amount ignored: same low byte, different upper bits
    issue(2'd0, fixed_word(1'b1, 4'hE, 4'd1, 4'd2, 2'd0, 4'd3), 1'b0, 32'h0000_00F1, 32'hFFFF_FF04, 1'b0, 1'b0, 1'b0);
    chk("R1 result", result, 32'h0000_0F10);
    chk("R1 carry", 32'(carry_out), 32'd0);

    // R7 field decode and no-flag variant (R6 pass-through)
    issue(2'd0, fixed_word(1'b0, 4'h0, 4'd5, 4'd9, 2'd2, 4'd12), 1'b0, 32'h8000_0000, 32'd1, 1'b0, 1'b1, 1'b1);
    chk("R7 rd", 32'(rd_idx), 32'd5);
    chk("R7 rs", 32'(rs_idx), 32'd9);
    chk("R7 rm", 32'(rm_idx), 32'd12);
    chk("R7 kind", 32'(shift_kind), 32'd2);
    chk("R7 foreign", 32'(foreign), 32'd0);
    chk("R6 no set flags_we", 32'(flags_we), 32'd0);
    chk("R6 pass n", 32'(flag_n), 32'd1);
    chk("R6 pass z", 32'(flag_z), 32'd1);
    chk("R6 pass c", 32'(flag_c), 32'd0);
    chk("R4 result", result, 32'hC000_0000);

    // R7 condition 1111 is foreign
    issue(2'd0, fixed_word(1'b1, 4'hF, 4'd1, 4'd2, 2'd0, 4'd3), 1'b0, 32'd1, 32'd1, 1'b0, 1'b0, 1'b0);
    chk("R7 cond15 foreign", 32'(foreign), 32'd1);
    chk("R9 foreign flags_we", 32'(flags_we), 32'd0);

    // R11 register 15 in fixed format
    issue(2'd0, fixed_word(1'b1, 4'hE, 4'd15, 4'd2, 2'd0, 4'd3), 1'b0, 32'd1, 32'd1, 1'b0, 1'b0, 1'b0);
    chk("R11 fixed rd15", 32'(unpred), 32'd1);
    issue(2'd0, fixed_word(1'b1, 4'hE, 4'd1, 4'd2, 2'd0, 4'd3), 1'b0, 32'd1, 32'd1, 1'b0, 1'b0, 1'b0);
    chk("R11 fixed clean", 32'(unpred), 32'd0);

    // R8 compact LSR, Rs=5, Rdm=6, outside conditional block
    issue(2'd1, {16'h0, 6'b010000, 4'b0011, 3'd5, 3'd6}, 1'b0, 32'h0000_0100, 32'd8, 1'b0, 1'b0, 1'b0);
    chk("R8 kind", 32'(shift_kind), 32'd1);
    chk("R8 rs", 32'(rs_idx), 32'd5);
    chk("R8 rd", 32'(rd_idx), 32'd6);
    chk("R8 rm", 32'(rm_idx), 32'd6);
    chk("R8 flags_we outside", 32'(flags_we), 32'd1);
    chk("R8 result", result, 32'h0000_0001);
    // R8 inside conditional block: no flag write
    issue(2'd1, {16'h0, 6'b010000, 4'b0100, 3'd1, 3'd2}, 1'b1, 32'h8000_0000, 32'd0, 1'b1, 1'b0, 1'b1);
    chk("R8 kind asr", 32'(shift_kind), 32'd2);
    chk("R8 flags_we inside", 32'(flags_we), 32'd0);
    chk("R8 pass z", 32'(flag_z), 32'd1);
    chk("R8 pass n", 32'(flag_n), 32'd0);
    // R8 rotate op
    issue(2'd1, {16'h0, 6'b010000, 4'b0111, 3'd1, 3'd2}, 1'b0, 32'h0000_0002, 32'd1, 1'b0, 1'b0, 1'b0);
    chk("R8 kind ror", 32'(shift_kind), 32'd3);
    chk("R8 ror result", result, 32'h0000_0001);

    // R9 compact op not in the set, and format 3
    issue(2'd1, {16'h0, 6'b010000, 4'b0000, 3'd1, 3'd2}, 1'b0, 32'd1, 32'd1, 1'b0, 1'b0, 1'b0);
    chk("R9 bad op foreign", 32'(foreign), 32'd1);
    chk("R9 bad op flags_we", 32'(flags_we), 32'd0);
    chk("R11 compact unpred", 32'(unpred), 32'd0);
    issue(2'd3, 32'h0, 1'b0, 32'd1, 32'd1, 1'b0, 1'b0, 1'b0);
    chk("R9 fmt3 foreign", 32'(foreign), 32'd1);

    // R10 wide compact: ASR, S=1, Rm=4, Rd=7, Rs=9
    issue(2'd2, {9'b111110100, 2'b10, 1'b1, 4'd4, 4'hF, 4'd7, 4'h0, 4'd9}, 1'b0, 32'h8000_0000, 32'd31, 1'b0, 1'b0, 1'b0);
    chk("R10 rm", 32'(rm_idx), 32'd4);
    chk("R10 rd", 32'(rd_idx), 32'd7);
    chk("R10 rs", 32'(rs_idx), 32'd9);
    chk("R10 kind", 32'(shift_kind), 32'd2);
    chk("R10 flags_we", 32'(flags_we), 32'd1);
    chk("R10 foreign", 32'(foreign), 32'd0);
    chk("R10 result", result, 32'hFFFF_FFFF);
    // R10 S=0 and R11 Rs=15
    issue(2'd2, {9'b111110100, 2'b00, 1'b0, 4'd4, 4'hF, 4'd7, 4'h0, 4'd15}, 1'b0, 32'd1, 32'd1, 1'b0, 1'b0, 1'b0);
    chk("R10 S0 flags_we", 32'(flags_we), 32'd0);
    chk("R11 wide rs15", 32'(unpred), 32'd1);

    // R12 synchronous reset clears outputs
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R12 reset clears result", result, 32'd0);
    chk("R12 reset clears unpred", 32'(unpred), 32'd0);
    rst = 1'b0;

    finish_run();
  end
endmodule